// File: doc/BRIEF.md
# Operand Bypass and Interlock Controller

This block decides where the ALU of a five-stage integer pipeline (fetch, decode, execute, memory access, write-back) takes its two operands from, and when the front of the pipeline must wait. It compares the source register numbers of the instructions in decode and in execute against the destination numbers of the older instructions in execute, in the execute/memory latch and in the memory/write-back latch. From this comparison it produces a select code for each ALU operand multiplexer, a hold signal for the program counter and the fetch/decode latch, and a bubble signal that clears the write-enables of the decode/execute latch.

The register file is written in the first half of a cycle and read in the second half. An instruction in decode therefore always sees the value that write-back commits in the same cycle. A design-time parameter picks one of two variants. The first gives full bypassing, with a single-cycle interlock only when a load feeds the very next instruction. The second is a pure interlock: the consumer waits in decode until its producer has reached write-back.

The block is purely combinational. It sits between the pipeline latches and the datapath multiplexers.

Top module: `hazard_ctrl`

## Requirements
- R1: With bypassing enabled, an execute-stage source that equals the execute/memory destination (write-enable set, register not 0) selects code 2'b10 for that operand.
- R2: With bypassing enabled, an execute-stage source that equals the memory/write-back destination (write-enable set, register not 0), and has no execute/memory match, selects code 2'b01.
- R3: When both latches match the same source, the execute/memory latch wins and code 2'b10 is selected.
- R4: Register 0 is never bypassed and never causes a hold. A destination whose write-enable is clear never matches.
- R5: An operand with no match selects code 2'b00, the register file value.
- R6: With bypassing enabled, the front is held when the instruction in execute is a load (write-enable set, destination not 0) whose destination equals either decode source.
- R7: With bypassing enabled, a non-load in execute never causes a hold.
- R8: With bypassing disabled, both selects stay at 2'b00. The front is held when a decode source equals the destination of the execute stage or of the execute/memory latch. A match with the memory/write-back latch causes no hold, so a consumer right behind an ALU producer waits exactly two cycles.
- R9: The bubble signal for the decode/execute latch is asserted in exactly the cycles in which the front is held.
- R10: The two operands are resolved independently, so one can come from execute/memory and the other from memory/write-back in the same cycle without a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | AW | First source register of the instruction in decode |
| id_rs2 | input | AW | Second source register of the instruction in decode |
| ex_rs1 | input | AW | First source register of the instruction in execute |
| ex_rs2 | input | AW | Second source register of the instruction in execute |
| ex_rd | input | AW | Destination register of the instruction in execute |
| ex_we | input | 1 | Register write-enable of the instruction in execute |
| ex_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | AW | Destination held in the execute/memory latch |
| mem_we | input | 1 | Write-enable held in the execute/memory latch |
| wb_rd | input | AW | Destination held in the memory/write-back latch |
| wb_we | input | 1 | Write-enable held in the memory/write-back latch |
| opa_sel | output | 2 | Operand A source: 00 register file, 01 memory/write-back, 10 execute/memory |
| opb_sel | output | 2 | Operand B source, same coding as opa_sel |
| hold_front | output | 1 | Keep the program counter and the fetch/decode latch unchanged |
| idex_bubble | output | 1 | Load a bubble with cleared write-enables into decode/execute |

## Verification
A wrong select code shows up at once, in the same cycle, as the wrong value reaching the ALU. In the full pipeline this would silently corrupt the consumer's result one write-back later. A missing hold lets a load consumer read a stale operand. A spurious hold only costs cycles, so the hold and bubble outputs are compared on every vector against an independent model, and the stall-only variant is also stepped through a producer's walk down the pipeline to count its waiting cycles. Because the block has no state, any error is visible in the very vector that provokes it.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_MEMWB   = 2'b01,
    SRC_EXMEM   = 2'b10
  } opnd_src_e;
endpackage

// File: rtl/hz_opnd_sel.sv
module hz_opnd_sel
  import hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output opnd_src_e     sel
);
  function automatic logic producer_hit(input logic [AW-1:0] s,
                                        input logic [AW-1:0] d,
                                        input logic we);
    return we && (d != '0) && (d == s);
  endfunction

  logic hit_exmem;
  logic hit_memwb;
  assign hit_exmem = producer_hit(src, mem_rd, mem_we);
  assign hit_memwb = producer_hit(src, wb_rd, wb_we);

  always_comb begin
    if (hit_exmem)      sel = SRC_EXMEM;
    else if (hit_memwb) sel = SRC_MEMWB;
    else                sel = SRC_REGFILE;
  end

  always_comb begin
    if (src == '0)
      AST_ZERO_REG_NOT_BYPASSED: assert (sel == SRC_REGFILE); // R4
    if (hit_exmem && hit_memwb)
      AST_YOUNGER_WINS: assert (sel == SRC_EXMEM); // R3
    if (sel == SRC_MEMWB)
      AST_MEMWB_NEEDS_WRITER: assert (wb_we && wb_rd == src); // R2
  end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
  parameter int AW     = 5,
  parameter bit FWD_EN = 1'b1
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  output logic          hold_front,
  output logic          idex_bubble
);
  function automatic logic reads_dest(input logic [AW-1:0] a,
                                      input logic [AW-1:0] b,
                                      input logic [AW-1:0] d,
                                      input logic we);
    return we && (d != '0) && ((d == a) || (d == b));
  endfunction

  logic ex_conflict;
  logic mem_conflict;
  assign ex_conflict  = reads_dest(id_rs1, id_rs2, ex_rd, ex_we);
  assign mem_conflict = reads_dest(id_rs1, id_rs2, mem_rd, mem_we);

  logic need_wait;
  generate
    if (FWD_EN) begin : g_bypass
      logic unused_mem;
      assign unused_mem = mem_conflict;
      assign need_wait  = ex_conflict && ex_load;
    end else begin : g_stall_only
      logic unused_load;
      assign unused_load = ex_load;
      assign need_wait   = ex_conflict || mem_conflict;
    end
  endgenerate

  assign hold_front  = need_wait;
  assign idex_bubble = need_wait;

  always_comb begin
    AST_BUBBLE_MATCHES_HOLD: assert (idex_bubble == hold_front); // R9
    if (FWD_EN && !ex_load)
      AST_ALU_PRODUCER_NO_WAIT: assert (!hold_front); // R7
    if (!ex_we && !mem_we)
      AST_NO_WRITER_NO_WAIT: assert (!hold_front); // R4
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int AW        = 5,
  parameter bit FORWARD_EN = 1'b1
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output logic [1:0]    opa_sel,
  output logic [1:0]    opb_sel,
  output logic          hold_front,
  output logic          idex_bubble
);
  localparam int NUM_OPND = 2;

  logic [AW-1:0] ex_src [NUM_OPND];
  opnd_src_e     src_sel [NUM_OPND];
  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;

  generate
    if (FORWARD_EN) begin : g_fwd
      for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
        hz_opnd_sel #(.AW(AW)) u_sel (
          .src    (ex_src[i]),
          .mem_rd (mem_rd),
          .mem_we (mem_we),
          .wb_rd  (wb_rd),
          .wb_we  (wb_we),
          .sel    (src_sel[i])
        );
      end
    end else begin : g_nofwd
      logic unused_srcs;
      assign unused_srcs = ^{ex_src[0], ex_src[1], wb_rd, wb_we};
      for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
        assign src_sel[i] = SRC_REGFILE;
      end
    end
  endgenerate

  assign opa_sel = src_sel[0];
  assign opb_sel = src_sel[1];

  hz_interlock #(.AW(AW), .FWD_EN(FORWARD_EN)) u_lock (
    .id_rs1      (id_rs1),
    .id_rs2      (id_rs2),
    .ex_rd       (ex_rd),
    .ex_we       (ex_we),
    .ex_load     (ex_load),
    .mem_rd      (mem_rd),
    .mem_we      (mem_we),
    .hold_front  (hold_front),
    .idex_bubble (idex_bubble)
  );

  always_comb begin
    if (!FORWARD_EN)
      AST_STALL_ONLY_NO_BYPASS: assert (opa_sel == 2'b00 && opb_sel == 2'b00); // R8
    AST_SEL_CODE_LEGAL: assert (opa_sel != 2'b11 && opb_sel != 2'b11); // R5
    if (mem_we && mem_rd != '0 && mem_rd == ex_rs1 && FORWARD_EN)
      AST_EXMEM_TO_OPA: assert (opa_sel == 2'b10); // R1
  end
endmodule

// File: tb/hazard_ctrl_test.sv
module hazard_ctrl_test;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0;
  logic [AW-1:0] ex_rd = '0, mem_rd = '0, wb_rd = '0;
  logic ex_we = 1'b0, ex_load = 1'b0, mem_we = 1'b0, wb_we = 1'b0;

  logic [1:0] f_a, f_b, s_a, s_b;
  logic f_hold, f_bub, s_hold, s_bub;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  hazard_ctrl #(.AW(AW), .FORWARD_EN(1'b1)) uut (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
    .opa_sel(f_a), .opb_sel(f_b), .hold_front(f_hold), .idex_bubble(f_bub)
  );

  hazard_ctrl #(.AW(AW), .FORWARD_EN(1'b0)) uut_stall (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
    .opa_sel(s_a), .opb_sel(s_b), .hold_front(s_hold), .idex_bubble(s_bub)
  );

  function automatic logic [1:0] want_sel(input logic [AW-1:0] s);
    if (s == 0) return 2'b00;
    if (mem_we && mem_rd == s) return 2'b10;
    if (wb_we && wb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic dep_on(input logic [AW-1:0] d, input logic we);
    return (d != 0) && we && (id_rs1 == d || id_rs2 == d);
  endfunction

  function automatic logic want_hold_fwd();
    return ex_load && dep_on(ex_rd, ex_we);
  endfunction

  function automatic logic want_hold_stall();
    return dep_on(ex_rd, ex_we) || dep_on(mem_rd, mem_we);
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " opa"}, f_a, want_sel(ex_rs1));
    check({tag, " opb"}, f_b, want_sel(ex_rs2));
    check({tag, " hold"}, {1'b0, f_hold}, {1'b0, want_hold_fwd()});
    check({"R9 ", tag}, {1'b0, f_bub}, {1'b0, f_hold});
    check({"R8 ", tag, " stall opa"}, s_a, 2'b00);
    check({"R8 ", tag, " stall opb"}, s_b, 2'b00);
    check({"R8 ", tag, " stall hold"}, {1'b0, s_hold}, {1'b0, want_hold_stall()});
    check({"R9 stall ", tag}, {1'b0, s_bub}, {1'b0, s_hold});
  endtask

  task automatic apply(input logic [AW-1:0] i1, i2, e1, e2, erd, input logic ewe, eld,
                       input logic [AW-1:0] mrd, input logic mwe,
                       input logic [AW-1:0] wrd, input logic wwe);
    @(negedge clk);
    id_rs1 = i1; id_rs2 = i2; ex_rs1 = e1; ex_rs2 = e2;
    ex_rd = erd; ex_we = ewe; ex_load = eld;
    mem_rd = mrd; mem_we = mwe; wb_rd = wrd; wb_we = wwe;
    #2;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1234;
    void'($urandom(seed));
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check_all("R5 idle");
    // R1: A from EX/MEM
    apply(0, 0, 3, 4, 0, 0, 0, 3, 1, 0, 0);
    check("R1 opa", f_a, 2'b10);
    // R2: B from MEM/WB
    apply(0, 0, 3, 4, 0, 0, 0, 0, 0, 4, 1);
    check("R2 opb", f_b, 2'b01);
    // R3: both latches write same reg
    apply(0, 0, 6, 6, 0, 0, 0, 6, 1, 6, 1);
    check("R3 opa", f_a, 2'b10);
    check("R3 opb", f_b, 2'b10);
    // R4: register 0 and cleared enables
    apply(0, 0, 0, 0, 0, 1, 1, 0, 1, 0, 1);
    check("R4 zero opa", f_a, 2'b00);
    check("R4 zero hold", {1'b0, f_hold}, 2'b00);
    check("R4 zero stall hold", {1'b0, s_hold}, 2'b00);
    apply(5, 5, 5, 5, 5, 0, 1, 5, 0, 5, 0);
    check("R4 we opa", f_a, 2'b00);
    check("R4 we hold", {1'b0, f_hold}, 2'b00);
    check("R4 we stall hold", {1'b0, s_hold}, 2'b00);
    // R6: load-use
    apply(2, 7, 0, 0, 7, 1, 1, 0, 0, 0, 0);
    check("R6 hold", {1'b0, f_hold}, 2'b01);
    check("R9 bubble", {1'b0, f_bub}, 2'b01);
    // R7: ALU producer in EX, no hold with bypass
    apply(7, 0, 0, 0, 7, 1, 0, 0, 0, 0, 0);
    check("R7 hold", {1'b0, f_hold}, 2'b00);
    // R8: producer walk EX -> MEM -> WB with stall-only variant
    apply(9, 0, 0, 0, 9, 1, 0, 0, 0, 0, 0);
    check("R8 wait1", {1'b0, s_hold}, 2'b01);
    apply(9, 0, 0, 0, 0, 0, 0, 9, 1, 0, 0);
    check("R8 wait2", {1'b0, s_hold}, 2'b01);
    apply(9, 0, 0, 0, 0, 0, 0, 0, 0, 9, 1);
    check("R8 go", {1'b0, s_hold}, 2'b00);
    // R10: two producers at distances one and two
    apply(0, 0, 1, 4, 0, 0, 0, 4, 1, 1, 1);
    check("R10 opa", f_a, 2'b01);
    check("R10 opb", f_b, 2'b10);
    check("R10 hold", {1'b0, f_hold}, 2'b00);
    for (int n = 0; n < 1500; n++) begin
      apply(AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
            AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
            AW'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
            AW'($urandom_range(0, 3)), 1'($urandom),
            AW'($urandom_range(0, 3)), 1'($urandom));
      check_all("R1 R2 R3 R6 rnd");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule